// File: doc/BRIEF.md
# Banked Lane Scratchpad with Conflict Serialization

This block is a shared on-chip scratchpad that serves a group of sixteen lane requests at a time. Storage is split into sixteen single-ported banks of 32-bit words, with neighbouring word addresses landing in neighbouring banks. Lane requests that land in different banks, or that read one and the same word, are served together in a single pass. Lanes that hit one bank at different words are spread over further passes.

A group is offered with `req_valid` and taken when `req_ready` is high. Each lane carries an active bit, a word address, a write flag and write data. While the group is in progress, `req_ready` stays low. When the last pass finishes, `rsp_done` pulses for one cycle. At that point `rsp_rdata` holds each lane's read word and `rsp_passes` gives the number of passes used. The group's completion time therefore depends on the access pattern. An odd address stride across lanes costs one pass. A stride of 16 costs sixteen.

Top module: `lane_scratchpad`

## Requirements
- R1: Word address `a` (8 bits, 256 words by default) is stored in bank `a mod 16` at row `a div 16`. Each bank performs at most one word access per pass.
- R2: `req_ready` is high exactly when no group is in progress. A group is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the group completes, and requests offered meanwhile are not taken.
- R3: The pass count P is found as follows. For each bank, count the distinct (address, write flag) pairs among the active lanes that map to it, and take the largest count; P is that count, and P is 1 if every count is zero. `rsp_done` is high for exactly one cycle, namely the cycle after the P-th rising edge that follows the accepting edge. At that point `rsp_passes` equals P.
- R4: A group whose active lanes all map to different banks (for example an odd lane stride) completes in one pass.
- R5: Any number of lanes reading one address are served together in one pass and all receive the same word.
- R6: In each pass, every bank picks its lowest-index pending lane as leader. It serves that lane together with every pending lane of the same address and same write flag. The rest stay pending for later passes.
- R7: When several lanes of one pass write the same address, the data of the highest-index such lane is stored.
- R8: A read returns the word as it stands at its pass. This includes writes made by earlier groups and by earlier passes of the same group.
- R9: Inactive lanes neither read nor write and add no passes. Write lanes and inactive lanes return zero in `rsp_rdata`. A group with no active lane completes in one pass.
- R10: While no group is in progress and none is being taken, `rsp_rdata` and `rsp_passes` hold their values.
- R11: During reset, `req_ready` is 1, `rsp_done` is 0, and `rsp_rdata` and `rsp_passes` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A lane group is offered |
| req_ready | output | 1 | Block idle, group can be taken |
| req_act | input | 16 | Per-lane active bit |
| req_wr | input | 16 | Per-lane write flag (1 = write, 0 = read) |
| req_addr | input | 128 | Per-lane word address, lane l in bits [8l+7:8l] |
| req_wdata | input | 512 | Per-lane write data, lane l in bits [32l+31:32l] |
| rsp_done | output | 1 | One-cycle pulse at group completion |
| rsp_rdata | output | 512 | Per-lane read data, lane l in bits [32l+31:32l] |
| rsp_passes | output | 5 | Number of passes the last group took |

## Verification
The assertions assume that each `rsp_done` belongs to the group most recently accepted. This holds because only one group is ever in flight, which lets the checker keep that group's read mask and flag an all-inactive group. The storage has no reset, so the read data checks assume that every word read has been written before. The stimulus first writes all 256 words in sixteen one-pass groups. It keeps `req_valid` and the lane fields at known values throughout. Lane fields are changed and `req_valid` is held high while a group is in progress, to show that the block latched the group and holds new requests off.

// File: rtl/sp_pkg.sv
// Shared types for the lane scratchpad.
// Assumes: nothing beyond a standard elaboration order (package first).
package sp_pkg;
    typedef enum logic {
        SP_IDLE = 1'b0,
        SP_BUSY = 1'b1
    } sp_state_e;
endpackage

// File: rtl/sp_bank_pick.sv
// Per-bank pass selector: picks the lowest-index pending lane that maps to
// this bank as leader, then marks every pending lane with the same address
// and direction as served in this pass. For merged writes the highest-index
// lane's data wins.
// Assumes: bank index is the low BW bits of a lane's word address.
module sp_bank_pick #(
    parameter int LANES   = 16,
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int BW      = 4,
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES-1:0]    wr,
    input  logic [LANES*AW-1:0] addr,
    input  logic [LANES*DW-1:0] wdata,
    output logic [LANES-1:0]    sel,
    output logic [AW-BW-1:0]    row,
    output logic                we,
    output logic [DW-1:0]       wdat
);
    localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

    logic          found;
    logic [AW-1:0] lead_addr;
    logic          lead_wr;

    // Leader search: scanning downwards leaves the lowest-index hit.
    always_comb begin
        found     = 1'b0;
        lead_addr = '0;
        lead_wr   = 1'b0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (pend[l] && (addr[l*AW +: BW] == MY_BANK)) begin
                found     = 1'b1;
                lead_addr = addr[l*AW +: AW];
                lead_wr   = wr[l];
            end
        end
    end

    // Served set: pending lanes sharing the leader's address and direction.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            sel[l] = found && pend[l] && (addr[l*AW +: AW] == lead_addr)
                     && (wr[l] == lead_wr);
        end
    end

    // Write data merge: the last (highest-index) served lane wins.
    always_comb begin
        wdat = '0;
        for (int l = 0; l < LANES; l++) begin
            if (sel[l]) begin
                wdat = wdata[l*DW +: DW];
            end
        end
    end

    assign we  = found && lead_wr;
    assign row = lead_addr[AW-1:BW];
endmodule

// File: rtl/sp_bank_mem.sv
// One single-ported bank: one write or one read per cycle on a single row
// address. Read is combinational from the row, write lands at the edge.
// Assumes: contents are not reset; words are written before being read.
module sp_bank_mem #(
    parameter int ROWS = 16,
    parameter int RW   = 4,
    parameter int DW   = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdat,
    output logic [DW-1:0] rdat
);
    logic [DW-1:0] cells [ROWS];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[row] <= wdat;
        end
    end

    assign rdat = cells[row];
endmodule

// File: rtl/lane_scratchpad.sv
// Banked lane scratchpad: takes one group of lane requests, serves it in as
// many passes as the worst bank needs, then pulses done with per-lane read
// data and the pass count.
// Assumes: BANKS is a power of two, AW > log2(BANKS), one group in flight.
module lane_scratchpad #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int DW    = 32,
    parameter int AW    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [LANES-1:0]          req_act,
    input  logic [LANES-1:0]          req_wr,
    input  logic [LANES*AW-1:0]       req_addr,
    input  logic [LANES*DW-1:0]       req_wdata,
    output logic                      rsp_done,
    output logic [LANES*DW-1:0]       rsp_rdata,
    output logic [$clog2(LANES+1)-1:0] rsp_passes
);
    import sp_pkg::*;

    localparam int BW   = $clog2(BANKS);
    localparam int RW   = AW - BW;
    localparam int ROWS = (2 ** AW) / BANKS;
    localparam int PW   = $clog2(LANES + 1);

    sp_state_e           state;
    logic [LANES-1:0]    pending;
    logic [LANES-1:0]    g_wr;
    logic [LANES*AW-1:0] g_addr;
    logic [LANES*DW-1:0] g_wdata;
    logic [PW-1:0]       pass_cnt;

    logic [LANES-1:0]    sel_b   [BANKS];
    logic [DW-1:0]       bank_rd [BANKS];
    logic [LANES-1:0]    served;
    logic [LANES-1:0]    nxt_pending;
    logic [DW-1:0]       lane_rd [LANES];

    // One selector and one storage bank per bank index.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [RW-1:0] row;
        logic          we;
        logic [DW-1:0] wdat;

        sp_bank_pick #(
            .LANES(LANES), .AW(AW), .DW(DW), .BW(BW), .BANK_ID(b)
        ) u_pick (
            .pend (pending),
            .wr   (g_wr),
            .addr (g_addr),
            .wdata(g_wdata),
            .sel  (sel_b[b]),
            .row  (row),
            .we   (we),
            .wdat (wdat)
        );

        sp_bank_mem #(
            .ROWS(ROWS), .RW(RW), .DW(DW)
        ) u_mem (
            .clk (clk),
            .we  (we && (state == SP_BUSY)),
            .row (row),
            .wdat(wdat),
            .rdat(bank_rd[b])
        );
    end

    // Union of the lanes every bank serves this pass.
    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) begin
            served = served | sel_b[b];
        end
    end

    assign nxt_pending = pending & ~served;

    // Route each lane to the read port of its own bank.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_rd[l] = bank_rd[g_addr[l*AW +: BW]];
        end
    end

    // Group sequencing: latch on accept, one pass per busy cycle, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SP_IDLE;
            pending    <= '0;
            g_wr       <= '0;
            g_addr     <= '0;
            g_wdata    <= '0;
            pass_cnt   <= '0;
            rsp_done   <= 1'b0;
            rsp_rdata  <= '0;
            rsp_passes <= '0;
        end else begin
            rsp_done <= 1'b0;
            case (state)
                SP_IDLE: begin
                    if (req_valid) begin
                        state     <= SP_BUSY;
                        pending   <= req_act;
                        g_wr      <= req_wr;
                        g_addr    <= req_addr;
                        g_wdata   <= req_wdata;
                        pass_cnt  <= '0;
                        rsp_rdata <= '0;
                    end
                end
                SP_BUSY: begin
                    pending  <= nxt_pending;
                    pass_cnt <= pass_cnt + PW'(1);
                    for (int l = 0; l < LANES; l++) begin
                        if (served[l] && !g_wr[l]) begin
                            rsp_rdata[l*DW +: DW] <= lane_rd[l];
                        end
                    end
                    if (nxt_pending == '0) begin
                        state      <= SP_IDLE;
                        rsp_done   <= 1'b1;
                        rsp_passes <= pass_cnt + PW'(1);
                    end
                end
                default: state <= SP_IDLE;
            endcase
        end
    end

    assign req_ready = (state == SP_IDLE);
endmodule

// File: rtl/sp_checker.sv
// Property checker for the lane scratchpad, bound to every instance.
// Assumes: one group in flight, so each done belongs to the last accept.
module sp_checker #(
    parameter int LANES = 16,
    parameter int DW    = 32,
    parameter int PW    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [LANES-1:0]    req_act,
    input logic [LANES-1:0]    req_wr,
    input logic                rsp_done,
    input logic [LANES*DW-1:0] rsp_rdata,
    input logic [PW-1:0]       rsp_passes
);
    logic [LANES-1:0] c_rdmask;
    logic             c_none;
    logic             zero_ok;

    // Remember which lanes of the accepted group are reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_rdmask <= '0;
            c_none   <= 1'b1;
        end else if (req_valid && req_ready) begin
            c_rdmask <= req_act & ~req_wr;
            c_none   <= (req_act == '0);
        end
    end

    // Non-read lanes must show zero data.
    always_comb begin
        zero_ok = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            if (!c_rdmask[l] && (rsp_rdata[l*DW +: DW] != '0)) begin
                zero_ok = 1'b0;
            end
        end
    end

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R3
    AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_passes >= PW'(1) && rsp_passes <= PW'(LANES))); // R3
    AST_QUIET_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> zero_ok); // R9
    AST_EMPTY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && c_none) |-> (rsp_passes == PW'(1))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> ($stable(rsp_rdata) && $stable(rsp_passes))); // R10
endmodule

bind lane_scratchpad sp_checker #(
    .LANES(LANES), .DW(DW), .PW($clog2(LANES + 1))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_act   (req_act),
    .req_wr    (req_wr),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .rsp_passes(rsp_passes)
);

// File: tb/sim_lane_scratchpad.sv
// Bench for the lane scratchpad: behavioural pass-by-pass model with its own
// word array, compared against the ports at every falling edge.
module sim_lane_scratchpad;
    localparam int LANES = 16;
    localparam int BANKS = 16;
    localparam int DW    = 32;
    localparam int AW    = 8;
    localparam int WORDS = 256;
    localparam int PW    = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [LANES-1:0]    req_act = '0;
    logic [LANES-1:0]    req_wr = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES*DW-1:0] req_wdata = '0;
    logic                rsp_done;
    logic [LANES*DW-1:0] rsp_rdata;
    logic [PW-1:0]       rsp_passes;

    always #4 clk = ~clk;

    lane_scratchpad #(.LANES(LANES), .BANKS(BANKS), .DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_act(req_act), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .rsp_passes(rsp_passes)
    );

    int errors = 0;
    int checks = 0;
    string tag = "R11";

    logic [DW-1:0] mem_m [WORDS];
    logic          exp_ready = 1'b1;
    logic          exp_done = 1'b0;
    logic [DW-1:0] exp_rd [LANES];
    int            exp_passes = 0;
    logic [DW-1:0] res_rd [LANES];
    int            res_passes = 0;
    int            remain = 0;

    function automatic int addr_of(input int l);
        return int'(req_addr[l*AW +: AW]);
    endfunction

    // Model one group: repeat passes until no lane is left pending.
    task automatic model_group();
        bit pend [LANES];
        bit any;
        int np = 0;
        for (int l = 0; l < LANES; l++) begin
            pend[l] = req_act[l];
            res_rd[l] = '0;
        end
        do begin
            bit take [LANES];
            for (int l = 0; l < LANES; l++) take[l] = 1'b0;
            for (int b = 0; b < BANKS; b++) begin
                int lead = -1;
                for (int l = 0; l < LANES; l++)
                    if (lead < 0 && pend[l] && (addr_of(l) % BANKS) == b) lead = l;
                if (lead >= 0)
                    for (int l = 0; l < LANES; l++)
                        if (pend[l] && addr_of(l) == addr_of(lead) && req_wr[l] == req_wr[lead])
                            take[l] = 1'b1;
            end
            for (int l = 0; l < LANES; l++)
                if (take[l] && !req_wr[l]) res_rd[l] = mem_m[addr_of(l)];
            for (int l = 0; l < LANES; l++)
                if (take[l] && req_wr[l]) mem_m[addr_of(l)] = req_wdata[l*DW +: DW];
            any = 1'b0;
            for (int l = 0; l < LANES; l++) begin
                if (take[l]) pend[l] = 1'b0;
                if (pend[l]) any = 1'b1;
            end
            np++;
        end while (any);
        res_passes = np;
    endtask

    task automatic compare();
        checks++;
        if (req_ready !== exp_ready) begin
            errors++;
            $display("FAIL R2 [%s] req_ready=%0b expected %0b", tag, req_ready, exp_ready);
        end
        checks++;
        if (rsp_done !== exp_done) begin
            errors++;
            $display("FAIL R3 [%s] rsp_done=%0b expected %0b", tag, rsp_done, exp_done);
        end
        if (exp_ready) begin
            checks++;
            if (rsp_passes !== PW'(exp_passes)) begin
                errors++;
                $display("FAIL %s rsp_passes=%0d expected %0d", tag, rsp_passes, exp_passes);
            end
            for (int l = 0; l < LANES; l++) begin
                checks++;
                if (rsp_rdata[l*DW +: DW] !== exp_rd[l]) begin
                    errors++;
                    $display("FAIL %s lane %0d rdata=%h expected %h", tag, l,
                             rsp_rdata[l*DW +: DW], exp_rd[l]);
                end
            end
        end
    endtask

    // Drive valid for the coming edge, advance the model, check after it.
    task automatic tick(input logic v);
        req_valid = v;
        if (exp_ready && v) begin
            model_group();
            remain    = res_passes;
            exp_ready = 1'b0;
            exp_done  = 1'b0;
        end else if (!exp_ready) begin
            remain--;
            if (remain == 0) begin
                exp_ready  = 1'b1;
                exp_done   = 1'b1;
                exp_passes = res_passes;
                for (int l = 0; l < LANES; l++) exp_rd[l] = res_rd[l];
            end else begin
                exp_done = 1'b0;
            end
        end else begin
            exp_done = 1'b0;
        end
        @(negedge clk);
        compare();
    endtask

    task automatic set_lane(input int l, input bit act, input bit wr,
                            input int a, input logic [DW-1:0] d);
        req_act[l] = act;
        req_wr[l]  = wr;
        req_addr[l*AW +: AW] = AW'(a % WORDS);
        req_wdata[l*DW +: DW] = d;
    endtask

    task automatic clear_all();
        for (int l = 0; l < LANES; l++) set_lane(l, 1'b0, 1'b0, 0, '0);
    endtask

    task automatic stride_read(input int base, input int s);
        for (int l = 0; l < LANES; l++) set_lane(l, 1'b1, 1'b0, base + s * l, '0);
    endtask

    // Offer the prepared group; optionally hold valid with new fields.
    task automatic run_group(input string t, input bit stay);
        tag = t;
        while (!exp_ready) tick(1'b0);
        tick(1'b1);
        for (int l = 0; l < LANES; l++)
            set_lane(l, 1'b1, l[0], l * 5 + 3, 32'hA500_0000 + l);
        while (!exp_ready) tick(stay);
        if (stay) begin
            tick(1'b1);
            while (!exp_ready) tick(1'b0);
        end
        tick(1'b0);
    endtask

    initial begin
        for (int l = 0; l < LANES; l++) exp_rd[l] = '0;
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        tick(1'b0);

        // R1: fill every word with stride-1 writes, one pass each
        for (int g = 0; g < 16; g++) begin
            for (int l = 0; l < LANES; l++)
                set_lane(l, 1'b1, 1'b1, g * 16 + l, {16'hC0DE, 8'(g), 8'(l)});
            run_group("R1", 1'b0);
        end
        stride_read(0, 1);   run_group("R1", 1'b0);
        stride_read(32, 1);  run_group("R1", 1'b0);
        // R4: odd strides are single-pass
        stride_read(7, 3);   run_group("R4", 1'b0);
        stride_read(100, 5); run_group("R4", 1'b0);
        // R3: even strides serialize
        stride_read(1, 2);   run_group("R3", 1'b0);
        stride_read(2, 4);   run_group("R3", 1'b0);
        stride_read(3, 16);  run_group("R3", 1'b0);
        // R5: broadcast of one word
        stride_read(37, 0);  run_group("R5", 1'b0);
        // R6: two addresses in bank 5, then write/read/write order in bank 2
        for (int l = 0; l < LANES; l++) set_lane(l, 1'b1, 1'b0, (l < 8) ? 5 : 21, '0);
        run_group("R6", 1'b0);
        clear_all();
        set_lane(0, 1'b1, 1'b1, 2, 32'h1111_2222);
        set_lane(1, 1'b1, 1'b0, 2, '0);
        set_lane(2, 1'b1, 1'b1, 18, 32'h3333_4444);
        set_lane(3, 1'b1, 1'b0, 3, '0);
        run_group("R6", 1'b0);
        // R7: merged writes keep the highest lane's data
        for (int l = 0; l < LANES; l++) set_lane(l, 1'b1, 1'b1, 9, 32'hBEEF_0000 + l);
        run_group("R7", 1'b0);
        stride_read(9, 0);   run_group("R7", 1'b0);
        // R8: read back words written by earlier groups
        stride_read(2, 16);  run_group("R8", 1'b0);
        // R9: inactive lanes carry conflicting writes that must be ignored
        for (int l = 0; l < LANES; l++) set_lane(l, 1'b0, 1'b1, 16 * l, 32'hDEAD_0000 + l);
        run_group("R9", 1'b0);
        for (int l = 0; l < LANES; l++)
            set_lane(l, l[0] == 1'b0, l[0] == 1'b0 ? 1'b0 : 1'b1, l[0] ? 16 * l : 64 + l, 32'hDEAD_1000);
        run_group("R9", 1'b0);
        stride_read(0, 16);  run_group("R9", 1'b0);
        // R2: valid held high with new fields while busy
        stride_read(4, 16);  run_group("R2", 1'b1);
        stride_read(3, 5);   run_group("R8", 1'b0);
        // R10: outputs hold through idle cycles
        tag = "R10";
        repeat (6) tick(1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog [%s] expired, expected completion", tag);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule